// File: doc/BRIEF.md
# DAC Sample Clock Sequencer

This block produces the sample clock that paces a switched-capacitor DAC. Once started, it first emits a burst of back-to-back active clock periods (the setup phase) to charge the output. It then moves to a hold phase that never ends by itself. In the hold phase, single active periods are spaced apart by a programmable number of idle periods, which refresh the held voltage at a low rate.

All timing is counted in base ticks, and a base tick is the input clock divided by a programmable ratio. The high time, low time, setup burst length and hold spacing are configuration inputs. They are captured in the cycle the sequencer leaves idle and are held until it returns to idle. When enable is cleared, the period in progress runs to its end, the clock parks low and both status outputs drop. Enable should only be raised again once both status outputs read 0.

Top module: `dac_smpl_seq`

## Requirements
- R1: After reset, `smpl_clk`, `setup_busy` and `hold_busy` are 0.
- R2: One base tick lasts `cfg_div`+1 input clock cycles, for `cfg_div` from 0 to 63.
- R3: In each active period the clock is high first: for 2 base ticks when `cfg_high_long` is 0, and for 4 base ticks when it is 1. The clock goes high in the first cycle after the cycle in which enable is seen high while idle.
- R4: After the high time, an active period is low for `cfg_low`+1 base ticks.
- R5: The setup phase consists of `cfg_setup`+1 consecutive active periods. `setup_busy` is 1 exactly during these periods.
- R6: The hold phase starts with an active period. Each active hold period is followed by `cfg_hold` inactive periods (0 to 255), during which the clock stays low. `hold_busy` is 1 for as long as the hold phase lasts.
- R7: An inactive period lasts as many base ticks as an active period, which is the high time plus the low time.
- R8: If enable is 0 in the last cycle of a period, the sequencer goes idle in the next cycle, with the clock low and both status outputs 0. Otherwise the next period follows.
- R9: The configuration inputs are captured when the sequencer leaves idle. Changing them while the sequencer runs has no effect on the output.
- R10: `setup_busy` and `hold_busy` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start, and keep running, the sample clock |
| cfg_div | input | 6 | Base tick divide ratio minus one |
| cfg_high_long | input | 1 | High time: 0 gives 2 ticks, 1 gives 4 ticks |
| cfg_low | input | 2 | Low time in ticks, minus one |
| cfg_setup | input | 4 | Setup burst length in periods, minus one |
| cfg_hold | input | 8 | Inactive periods after each hold active period |
| smpl_clk | output | 1 | Sample clock to the DAC |
| setup_busy | output | 1 | Setup phase running |
| hold_busy | output | 1 | Hold phase running |

## Verification
The setup-to-hold handover and a disable request can both act at the end of the last setup period. One case therefore drops enable exactly in that final cycle. The bench then expects the sequencer to go straight to idle: `hold_busy` must never pulse, and the clock must stay low. Another case drops enable in the middle of an inactive hold period. There the whole idle period must run out before the status outputs clear. Every case is compared cycle by cycle against an independent period-walking model that is written in the bench.

// File: rtl/smpl_seq_pkg.sv
package smpl_seq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SETUP = 2'd1,
        SQ_HOLD  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/smpl_tick_div.sv
module smpl_tick_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == div);

    always_comb begin
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && div != '0) |=> !tick);
endmodule

// File: rtl/smpl_phase_ctrl.sv
module smpl_phase_ctrl
    import smpl_seq_pkg::*;
#(
    parameter int DIV_W   = 6,
    parameter int LOW_W   = 2,
    parameter int SETUP_W = 4,
    parameter int HOLD_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cfg_high_long,
    input  logic [LOW_W-1:0]   cfg_low,
    input  logic [SETUP_W-1:0] cfg_setup,
    input  logic [HOLD_W-1:0]  cfg_hold,
    input  logic               tick,
    output logic               run,
    output logic [DIV_W-1:0]   div_sel,
    output logic               smpl_clk,
    output logic               setup_busy,
    output logic               hold_busy
);
    localparam int CNT_W = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
    localparam int PH_W  = $clog2(4 + (1 << LOW_W));

    typedef struct packed {
        seq_state_e         st;
        logic [DIV_W-1:0]   div;
        logic               high_long;
        logic [LOW_W-1:0]   low;
        logic [SETUP_W-1:0] setup;
        logic [HOLD_W-1:0]  hold;
        logic [PH_W-1:0]    ph;
        logic [CNT_W-1:0]   cnt;
        logic               active;
    } seq_regs_t;

    seq_regs_t q, d;
    logic [PH_W-1:0] hi_ticks, last_ph;
    logic            per_end;

    assign hi_ticks = q.high_long ? PH_W'(4) : PH_W'(2);
    assign last_ph  = hi_ticks + PH_W'(q.low);
    assign per_end  = tick && (q.ph == last_ph);

    always_comb begin
        d = q;
        if (q.st == SQ_IDLE) begin
            if (enable) begin
                d.st        = SQ_SETUP;
                d.div       = cfg_div;
                d.high_long = cfg_high_long;
                d.low       = cfg_low;
                d.setup     = cfg_setup;
                d.hold      = cfg_hold;
                d.ph        = '0;
                d.cnt       = '0;
                d.active    = 1'b1;
            end
        end else if (tick) begin
            if (per_end) begin
                d.ph = '0;
                if (!enable) begin
                    d.st     = SQ_IDLE;
                    d.active = 1'b0;
                    d.cnt    = '0;
                end else if (q.st == SQ_SETUP) begin
                    if (q.cnt == CNT_W'(q.setup)) begin
                        d.st     = SQ_HOLD;
                        d.cnt    = '0;
                        d.active = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end else if (q.active) begin
                    if (q.hold != '0) begin
                        d.active = 1'b0;
                        d.cnt    = CNT_W'(1);
                    end
                end else if (q.cnt == CNT_W'(q.hold)) begin
                    d.active = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else begin
                d.ph = q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign run        = (q.st != SQ_IDLE);
    assign div_sel    = q.div;
    assign smpl_clk   = run && q.active && (q.ph < hi_ticks);
    assign setup_busy = (q.st == SQ_SETUP);
    assign hold_busy  = (q.st == SQ_HOLD);

    // R8
    stop_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> !$past(enable));

    // R5
    hold_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_busy) |-> $past(setup_busy));

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable({q.div, q.high_long, q.low, q.setup, q.hold}));
endmodule

// File: rtl/dac_smpl_seq.sv
module dac_smpl_seq #(
    parameter int DIV_W   = 6,
    parameter int LOW_W   = 2,
    parameter int SETUP_W = 4,
    parameter int HOLD_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cfg_high_long,
    input  logic [LOW_W-1:0]   cfg_low,
    input  logic [SETUP_W-1:0] cfg_setup,
    input  logic [HOLD_W-1:0]  cfg_hold,
    output logic               smpl_clk,
    output logic               setup_busy,
    output logic               hold_busy
);
    logic             run, tick;
    logic [DIV_W-1:0] div_sel;

    smpl_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (div_sel),
        .tick (tick)
    );

    smpl_phase_ctrl #(
        .DIV_W  (DIV_W),
        .LOW_W  (LOW_W),
        .SETUP_W(SETUP_W),
        .HOLD_W (HOLD_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .cfg_div      (cfg_div),
        .cfg_high_long(cfg_high_long),
        .cfg_low      (cfg_low),
        .cfg_setup    (cfg_setup),
        .cfg_hold     (cfg_hold),
        .tick         (tick),
        .run          (run),
        .div_sel      (div_sel),
        .smpl_clk     (smpl_clk),
        .setup_busy   (setup_busy),
        .hold_busy    (hold_busy)
    );

    // R10
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(setup_busy && hold_busy));

    // R3
    high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smpl_clk) |=> smpl_clk);
endmodule

// File: tb/dac_smpl_seq_tb.sv
module dac_smpl_seq_tb;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [5:0] cfg_div = '0;
    logic       cfg_high_long = 1'b0;
    logic [1:0] cfg_low = '0;
    logic [3:0] cfg_setup = '0;
    logic [7:0] cfg_hold = '0;
    logic       smpl_clk, setup_busy, hold_busy;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    dac_smpl_seq u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_div(cfg_div), .cfg_high_long(cfg_high_long), .cfg_low(cfg_low),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
        .smpl_clk(smpl_clk), .setup_busy(setup_busy), .hold_busy(hold_busy)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model: walk periods from cycle 0 (first cycle after start); returns {clk,setup,hold}
    function automatic logic [2:0] exp_at(int k, int kd, int dv, int hl, int lo,
                                         int su, int hd);
        int hi  = (hl != 0 ? 4 : 2) * (dv + 1);
        int per = ((hl != 0 ? 4 : 2) + lo + 1) * (dv + 1);
        int t   = 0;
        int idx = 0;
        while (1) begin
            bit in_setup = (idx <= su);
            bit act = in_setup ? 1'b1 : (((idx - su - 1) % (hd + 1)) == 0);
            if (k < t + per)
                return {act && ((k - t) < hi), in_setup, !in_setup};
            if (t + per - 1 >= kd) return 3'b000;
            t += per;
            idx++;
        end
        return 3'b000;
    endfunction

    task automatic run_case(string req, int dv, int hl, int lo, int su, int hd,
                            int kd, bit scramble);
        int per = ((hl != 0 ? 4 : 2) + lo + 1) * (dv + 1);
        int maxk = kd + per + 4;
        int clk_err = -1, st_err = -1;
        logic [2:0] got_c = '0, exp_c = '0, got_s = '0, exp_s = '0;
        @(negedge clk);
        cfg_div = 6'(dv); cfg_high_long = hl[0]; cfg_low = 2'(lo);
        cfg_setup = 4'(su); cfg_hold = 8'(hd);
        enable = 1'b1;
        for (int k = 0; k < maxk; k++) begin
            logic [2:0] g, e;
            @(negedge clk);
            g = {smpl_clk, setup_busy, hold_busy};
            e = exp_at(k, kd, dv, hl, lo, su, hd);
            if (g[2] != e[2] && clk_err < 0) begin clk_err = k; got_c = g; exp_c = e; end
            if (g[1:0] != e[1:0] && st_err < 0) begin st_err = k; got_s = g; exp_s = e; end
            if (scramble && k == 0) begin
                cfg_div = ~cfg_div; cfg_high_long = ~cfg_high_long; cfg_low = ~cfg_low;
                cfg_setup = ~cfg_setup; cfg_hold = ~cfg_hold;
            end
            if (k == kd) enable = 1'b0;
        end
        if (clk_err >= 0) $display("  %s clock mismatch at cycle %0d", req, clk_err);
        check({req, " clock waveform"}, int'(got_c[2]), int'(exp_c[2]));
        if (st_err >= 0) $display("  %s status mismatch at cycle %0d", req, st_err);
        check({req, " R5 R6 status"}, int'(got_s[1:0]), int'(exp_s[1:0]));
        check({req, " R8 parked idle"}, int'({smpl_clk, setup_busy, hold_busy}), 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during and after reset
        check("R1 reset outputs", int'({smpl_clk, setup_busy, hold_busy}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", int'({smpl_clk, setup_busy, hold_busy}), 0);

        run_case("R3 R4 basic",            0, 0, 0, 1, 2,  30, 1'b0);
        run_case("R2 R3 R4 divide4 long",  3, 1, 3, 0, 1, 100, 1'b0);
        run_case("R6 R7 long hold",        1, 0, 1, 2, 5, 150, 1'b0);
        run_case("R8 stop at setup end",   0, 0, 1, 1, 2,   7, 1'b0);
        run_case("R7 R8 stop in idle gap", 0, 0, 0, 0, 3,   7, 1'b0);
        run_case("R2 max divide",         63, 1, 3, 0, 0, 700, 1'b0);
        run_case("R9 cfg change ignored",  1, 0, 2, 3, 1, 120, 1'b1);
        run_case("R5 R10 max setup",       0, 1, 0, 15, 0, 110, 1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule